// File: doc/BRIEF.md
# Clause 45 Management Bus Device Responder

This block is the managed-device end of a two-wire station management bus. It is clocked directly by the management clock. It samples the bidirectional data line on every rising clock edge and looks for an idle run of at least 32 ones followed by a `00` start pattern. After that it collects the opcode and the two 5-bit address fields. Frames meant for another port or device are dropped, and so are frames that carry the unsupported opcode `10`. In those cases the line is never driven.

Accepted frames work through an internal 16-bit register pointer. An address frame loads the pointer. A write frame stores its payload at the location the pointer selects. A read frame returns the selected word. On a read, the responder leaves the first turnaround bit undriven, drives a zero in the second bit, then shifts out 16 data bits, most significant first. It then releases the line and goes back to hunting for a preamble.

The storage is a 16-entry file indexed by the low pointer bits. Local logic has its own write and read port into the same file. A pointer with any bit set above the index range selects nothing: it reads as zero and write frames to it are dropped.

Top module: `mmd_responder`

## Requirements
- R1: After reset the output enable is low, every storage entry reads zero on the local port, and the register pointer is zero.
- R2: A frame is accepted only when at least 32 consecutive ones precede the `00` start pattern. A frame led by only 31 ones changes nothing. A longer run of ones is accepted.
- R3: A frame with opcode `00` loads its 16-bit payload into the register pointer. A frame with opcode `01` stores its payload in the entry the pointer selects, and the new value is visible on the local read port in the cycle after the last payload bit.
- R4: A frame with opcode `11` keeps the output enable low for the first turnaround bit. It drives 0 for the second turnaround bit, then drives the 16 bits of the selected entry, most significant bit first, one per clock. The output enable falls after the last data bit, so the line is driven for exactly 17 bit times.
- R5: A frame with opcode `10` is ignored. It never drives the line and changes neither the storage nor the pointer.
- R6: The port field (5 bits, first after the opcode) and the device field (5 bits, next) are received most significant bit first. When either one differs from the configured value, the frame neither drives the line nor writes storage.
- R7: A pointer with a nonzero bit at position 4 or above reads back as 0x0000 through a read frame. A write frame to such a pointer changes no entry.
- R8: When the local write enable is high at a rising clock edge, the local data is stored in the entry at the local index. The stored value is visible both on the local read port and to read frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Value driven onto the data line while enabled |
| mdio_oe | output | 1 | High while the responder drives the data line |
| cfg_port | input | 5 | Port address this responder answers to |
| cfg_dev | input | 5 | Device address this responder answers to |
| lcl_we | input | 1 | Local write strobe |
| lcl_idx | input | $clog2(DEPTH) | Local entry index for reads and writes |
| lcl_wdata | input | DATA_W | Local write data |
| lcl_rdata | output | DATA_W | Contents of the entry at lcl_idx |

## Verification
The assertions rely on frames arriving whole, with the station releasing the line during the turnaround and data bits of a read. They also rely on the data input changing only away from the rising clock edge, and on the configured addresses staying constant while a frame is in flight. The bench drives every bit on the falling edge and models a pull-up whenever neither side drives. It keeps the configuration fixed for the whole run, and it uses the local write port only while the bus is idle, so a local store and a bus store never land in the same cycle.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  typedef enum logic [2:0] {
    S_HUNT,
    S_START,
    S_HDR,
    S_TA1,
    S_TA2,
    S_DATA
  } mmd_state_e;

  localparam logic [1:0] OP_ADDR = 2'b00;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] OP_INC  = 2'b10;
  localparam logic [1:0] OP_RD   = 2'b11;

  localparam int FLD_W = 5;
  localparam int HDR_W = 2 + 2 * FLD_W;
endpackage

// File: rtl/mmd_frame_fsm.sv
module mmd_frame_fsm
  import mmd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_i,
  input  logic [FLD_W-1:0]  cfg_port,
  input  logic [FLD_W-1:0]  cfg_dev,
  input  logic [DATA_W-1:0] rd_word,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              addr_ld,
  output logic              wr_en,
  output logic [DATA_W-1:0] data_word,
  output logic              hunting,
  output logic [1:0]        op
);
  localparam int PRE_W = $clog2(PRE_LEN + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [PRE_W-1:0] PRE_FULL = PRE_W'(PRE_LEN);
  localparam logic [BIT_W-1:0] HDR_LAST = BIT_W'(HDR_W - 1);
  localparam logic [BIT_W-1:0] DAT_LAST = BIT_W'(DATA_W - 1);

  mmd_state_e        state_q, state_n;
  logic [PRE_W-1:0]  pre_q, pre_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [HDR_W-1:0]  hdr_q, hdr_n, hdr_shift;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              oe_q, oe_n, o_q, o_n;
  logic              is_rd;

  assign hdr_shift = {hdr_q[HDR_W-2:0], mdio_i};
  assign is_rd     = (hdr_q[HDR_W-1 -: 2] == OP_RD);
  assign data_word = {sh_q[DATA_W-2:0], mdio_i};

  always_comb begin
    state_n = state_q;
    pre_n   = pre_q;
    bit_n   = bit_q;
    hdr_n   = hdr_q;
    sh_n    = sh_q;
    oe_n    = oe_q;
    o_n     = o_q;
    addr_ld = 1'b0;
    wr_en   = 1'b0;
    case (state_q)
      S_HUNT: begin
        if (mdio_i) begin
          pre_n = (pre_q == PRE_FULL) ? pre_q : pre_q + 1'b1;
        end else begin
          pre_n = '0;
          if (pre_q == PRE_FULL) state_n = S_START;
        end
      end
      S_START: begin
        bit_n = '0;
        if (!mdio_i) begin
          state_n = S_HDR;
        end else begin
          state_n = S_HUNT;
          pre_n   = PRE_W'(1);
        end
      end
      S_HDR: begin
        hdr_n = hdr_shift;
        bit_n = bit_q + 1'b1;
        if (bit_q == HDR_LAST) begin
          bit_n = '0;
          if (hdr_shift[2*FLD_W-1 -: FLD_W] == cfg_port &&
              hdr_shift[FLD_W-1:0] == cfg_dev &&
              hdr_shift[HDR_W-1 -: 2] != OP_INC) begin
            state_n = S_TA1;
          end else begin
            state_n = S_HUNT;
          end
        end
      end
      S_TA1: begin
        state_n = S_TA2;
        if (is_rd) begin
          oe_n = 1'b1;
          o_n  = 1'b0;
          sh_n = rd_word;
        end
      end
      S_TA2: begin
        state_n = S_DATA;
        bit_n   = '0;
        if (is_rd) begin
          o_n  = sh_q[DATA_W-1];
          sh_n = {sh_q[DATA_W-2:0], 1'b0};
        end
      end
      S_DATA: begin
        bit_n = bit_q + 1'b1;
        if (is_rd) begin
          if (bit_q == DAT_LAST) begin
            oe_n    = 1'b0;
            o_n     = 1'b0;
            state_n = S_HUNT;
          end else begin
            o_n  = sh_q[DATA_W-1];
            sh_n = {sh_q[DATA_W-2:0], 1'b0};
          end
        end else begin
          sh_n = data_word;
          if (bit_q == DAT_LAST) begin
            state_n = S_HUNT;
            addr_ld = (hdr_q[HDR_W-1 -: 2] == OP_ADDR);
            wr_en   = (hdr_q[HDR_W-1 -: 2] == OP_WR);
          end
        end
      end
      default: state_n = S_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HUNT;
      pre_q   <= '0;
      bit_q   <= '0;
      hdr_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      o_q     <= 1'b0;
    end else begin
      state_q <= state_n;
      pre_q   <= pre_n;
      bit_q   <= bit_n;
      hdr_q   <= hdr_n;
      sh_q    <= sh_n;
      oe_q    <= oe_n;
      o_q     <= o_n;
    end
  end

  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign hunting = (state_q == S_HUNT);
  assign op      = hdr_q[HDR_W-1 -: 2];
endmodule

// File: rtl/mmd_regfile.sv
module mmd_regfile #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lcl_we,
  input  logic [IDX_W-1:0]  lcl_idx,
  input  logic [DATA_W-1:0] lcl_wdata,
  output logic [DATA_W-1:0] lcl_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  bus_idx;
  logic              in_range;

  assign bus_idx  = bus_addr[IDX_W-1:0];
  assign in_range = ((bus_addr >> IDX_W) == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic bus_hit, lcl_hit;
    assign bus_hit = bus_we && in_range && (bus_idx == IDX_W'(g));
    assign lcl_hit = lcl_we && (lcl_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (bus_hit) begin
        mem[g] <= bus_wdata;
      end else if (lcl_hit) begin
        mem[g] <= lcl_wdata;
      end
    end
  end

  assign bus_rdata = in_range ? mem[bus_idx] : '0;
  assign lcl_rdata = mem[lcl_idx];
endmodule

// File: rtl/mmd_responder.sv
module mmd_responder
  import mmd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int DEPTH   = 16,
  parameter int PRE_LEN = 32
) (
  input  logic                     mdc,
  input  logic                     rst_n,
  input  logic                     mdio_i,
  output logic                     mdio_o,
  output logic                     mdio_oe,
  input  logic [4:0]               cfg_port,
  input  logic [4:0]               cfg_dev,
  input  logic                     lcl_we,
  input  logic [$clog2(DEPTH)-1:0] lcl_idx,
  input  logic [DATA_W-1:0]        lcl_wdata,
  output logic [DATA_W-1:0]        lcl_rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_word, data_word;
  logic              addr_ld, wr_en, fsm_hunting;
  logic [1:0]        fsm_op;

  mmd_frame_fsm #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_fsm (
    .clk      (mdc),
    .rst_n    (rst_n),
    .mdio_i   (mdio_i),
    .cfg_port (cfg_port),
    .cfg_dev  (cfg_dev),
    .rd_word  (rd_word),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .addr_ld  (addr_ld),
    .wr_en    (wr_en),
    .data_word(data_word),
    .hunting  (fsm_hunting),
    .op       (fsm_op)
  );

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_ld) begin
      addr_q <= ADDR_W'(data_word);
    end
  end

  mmd_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_rf (
    .clk      (mdc),
    .rst_n    (rst_n),
    .bus_addr (addr_q),
    .bus_we   (wr_en),
    .bus_wdata(data_word),
    .bus_rdata(rd_word),
    .lcl_we   (lcl_we),
    .lcl_idx  (lcl_idx),
    .lcl_wdata(lcl_wdata),
    .lcl_rdata(lcl_rdata)
  );
endmodule

// File: rtl/mmd_responder_chk.sv
module mmd_responder_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mdio_oe,
  input logic              mdio_o,
  input logic              hunting,
  input logic [1:0]        op,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] rd_word,
  input logic              addr_ld
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int RUN_W = $clog2(DATA_W + 3);

  logic [RUN_W-1:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_run <= '0;
    end else if (mdio_oe) begin
      if (oe_run != RUN_W'(DATA_W + 2)) oe_run <= oe_run + 1'b1;
    end else begin
      oe_run <= '0;
    end
  end

  assert_first_drive_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  assert_release_to_hunt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> hunting);

  assert_drive_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_run <= RUN_W'(DATA_W + 1));

  assert_drive_only_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (op == 2'b11));

  assert_addr_from_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> $past(addr_ld));

  assert_oob_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_q >> IDX_W) != '0) |-> (rd_word == '0));
endmodule

bind mmd_responder mmd_responder_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
) u_chk (
  .clk    (mdc),
  .rst_n  (rst_n),
  .mdio_oe(mdio_oe),
  .mdio_o (mdio_o),
  .hunting(fsm_hunting),
  .op     (fsm_op),
  .addr_q (addr_q),
  .rd_word(rd_word),
  .addr_ld(addr_ld)
);

// File: tb/mmd_responder_bench.sv
`timescale 1ns/1ps
module mmd_responder_bench;
  localparam logic [4:0] MY_PORT = 5'h0B;
  localparam logic [4:0] MY_DEV  = 5'h15;

  logic        mdc, rst_n;
  logic        mdio_o, mdio_oe;
  logic        sta_bit, sta_z;
  logic        line;
  logic        lcl_we;
  logic [3:0]  lcl_idx;
  logic [15:0] lcl_wdata, lcl_rdata;
  int          total, bad;

  assign line = mdio_oe ? mdio_o : (sta_z ? 1'b1 : sta_bit);

  mmd_responder u_mmd_responder (
    .mdc      (mdc),
    .rst_n    (rst_n),
    .mdio_i   (line),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .cfg_port (MY_PORT),
    .cfg_dev  (MY_DEV),
    .lcl_we   (lcl_we),
    .lcl_idx  (lcl_idx),
    .lcl_wdata(lcl_wdata),
    .lcl_rdata(lcl_rdata)
  );

  initial mdc = 1'b0;
  always #5 mdc = ~mdc;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge mdc);
      sta_bit = v[i];
      @(posedge mdc);
    end
  endtask

  task automatic send_hdr(input int pre_len, input logic [1:0] op,
                          input logic [4:0] prt, input logic [4:0] dev);
    sta_z = 1'b0;
    send_bits(0, 1);
    for (int i = 0; i < pre_len; i++) send_bits(1, 1);
    send_bits(0, 2);
    send_bits({30'd0, op}, 2);
    send_bits({27'd0, prt}, 5);
    send_bits({27'd0, dev}, 5);
  endtask

  task automatic wr_frame(input int pre_len, input logic [1:0] op, input logic [4:0] prt,
                          input logic [4:0] dev, input logic [15:0] data);
    send_hdr(pre_len, op, prt, dev);
    send_bits(2, 2);
    send_bits({16'd0, data}, 16);
    @(negedge mdc);
    sta_bit = 1'b1;
  endtask

  task automatic rd_frame(input string req, input logic [1:0] op, input logic [4:0] prt,
                          input logic [4:0] dev, input logic drive, input logic [15:0] exp);
    logic [15:0] got;
    logic        all_oe, any_oe;
    send_hdr(32, op, prt, dev);
    sta_z = 1'b1;
    @(negedge mdc);
    check({req, " first turnaround bit undriven"}, {31'd0, mdio_oe}, 0);
    if (drive) begin
      @(negedge mdc);
      check({req, " second turnaround bit drives 0"}, {30'd0, mdio_oe, mdio_o}, 2);
      all_oe = 1'b1;
      for (int i = 15; i >= 0; i--) begin
        @(negedge mdc);
        got[i] = mdio_o;
        all_oe = all_oe & mdio_oe;
      end
      check({req, " read data"}, {16'd0, got}, {16'd0, exp});
      check({req, " enabled through data"}, {31'd0, all_oe}, 1);
      @(negedge mdc);
      check({req, " release after last bit"}, {31'd0, mdio_oe}, 0);
    end else begin
      any_oe = 1'b0;
      for (int i = 0; i < 18; i++) begin
        @(negedge mdc);
        any_oe = any_oe | mdio_oe;
      end
      check({req, " never drives"}, {31'd0, any_oe}, 0);
    end
    sta_z   = 1'b0;
    sta_bit = 1'b1;
  endtask

  task automatic lcl_write(input logic [3:0] idx, input logic [15:0] d);
    @(negedge mdc);
    lcl_we = 1'b1; lcl_idx = idx; lcl_wdata = d;
    @(negedge mdc);
    lcl_we = 1'b0;
  endtask

  task automatic lcl_peek(input string req, input logic [3:0] idx, input logic [15:0] exp);
    lcl_idx = idx;
    #1;
    check(req, {16'd0, lcl_rdata}, {16'd0, exp});
  endtask

  task automatic t_reset;
    check("R1 oe low after reset", {31'd0, mdio_oe}, 0);
    lcl_peek("R1 entry 0 zero", 4'd0, 16'h0000);
    lcl_peek("R1 entry 15 zero", 4'd15, 16'h0000);
    rd_frame("R1 pointer zero reads entry 0", 2'b11, MY_PORT, MY_DEV, 1'b1, 16'h0000);
  endtask

  task automatic t_addr_write_read;
    wr_frame(32, 2'b00, MY_PORT, MY_DEV, 16'h0003);
    wr_frame(32, 2'b01, MY_PORT, MY_DEV, 16'hA5C3);
    lcl_peek("R3 write lands at pointer", 4'd3, 16'hA5C3);
    lcl_peek("R3 neighbour untouched", 4'd2, 16'h0000);
    rd_frame("R4 read back", 2'b11, MY_PORT, MY_DEV, 1'b1, 16'hA5C3);
  endtask

  task automatic t_preamble;
    wr_frame(31, 2'b01, MY_PORT, MY_DEV, 16'h1111);
    lcl_peek("R2 short preamble ignored", 4'd3, 16'hA5C3);
    wr_frame(40, 2'b01, MY_PORT, MY_DEV, 16'h5A5A);
    lcl_peek("R2 long preamble accepted", 4'd3, 16'h5A5A);
  endtask

  task automatic t_mismatch;
    wr_frame(32, 2'b01, 5'h0A, MY_DEV, 16'h0BAD);
    lcl_peek("R6 wrong port no write", 4'd3, 16'h5A5A);
    wr_frame(32, 2'b01, MY_PORT, 5'h14, 16'h0BAD);
    lcl_peek("R6 wrong device no write", 4'd3, 16'h5A5A);
    rd_frame("R6 wrong port read", 2'b11, 5'h1B, MY_DEV, 1'b0, 16'h0000);
    rd_frame("R6 wrong device read", 2'b11, MY_PORT, 5'h05, 1'b0, 16'h0000);
  endtask

  task automatic t_op10;
    wr_frame(32, 2'b10, MY_PORT, MY_DEV, 16'h0007);
    lcl_peek("R5 opcode 10 no store", 4'd3, 16'h5A5A);
    lcl_peek("R5 opcode 10 no store at payload index", 4'd7, 16'h0000);
    rd_frame("R5 opcode 10 read-style", 2'b10, MY_PORT, MY_DEV, 1'b0, 16'h0000);
    rd_frame("R5 pointer kept", 2'b11, MY_PORT, MY_DEV, 1'b1, 16'h5A5A);
  endtask

  task automatic t_oob;
    lcl_write(4'd0, 16'hC0DE);
    wr_frame(32, 2'b00, MY_PORT, MY_DEV, 16'h0010);
    rd_frame("R7 out of range reads zero", 2'b11, MY_PORT, MY_DEV, 1'b1, 16'h0000);
    wr_frame(32, 2'b01, MY_PORT, MY_DEV, 16'hFFFF);
    lcl_peek("R7 out of range write dropped", 4'd0, 16'hC0DE);
    wr_frame(32, 2'b00, MY_PORT, MY_DEV, 16'h8000);
    rd_frame("R7 top bit out of range", 2'b11, MY_PORT, MY_DEV, 1'b1, 16'h0000);
  endtask

  task automatic t_local;
    lcl_write(4'd7, 16'h1234);
    lcl_peek("R8 local write visible", 4'd7, 16'h1234);
    wr_frame(32, 2'b00, MY_PORT, MY_DEV, 16'h0007);
    rd_frame("R8 local write seen by bus", 2'b11, MY_PORT, MY_DEV, 1'b1, 16'h1234);
    wr_frame(32, 2'b00, MY_PORT, MY_DEV, 16'h000F);
    wr_frame(32, 2'b01, MY_PORT, MY_DEV, 16'hFEED);
    lcl_peek("R3 last entry written", 4'd15, 16'hFEED);
  endtask

  initial begin
    repeat (100000) @(posedge mdc);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; sta_bit = 1'b1; sta_z = 1'b0;
    lcl_we = 1'b0; lcl_idx = '0; lcl_wdata = '0;
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    t_reset;
    t_addr_write_read;
    t_preamble;
    t_mismatch;
    t_op10;
    t_oob;
    t_local;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule